// File: doc/BRIEF.md
# SPI Transmit Queue with Retained Control Word

This block is the processor-facing queue stage of an SPI master. Software writes transmit words into a single write register with byte, half-word or full-word accesses, chosen by byte strobes. Each accepted write adds one 32-bit entry to an 8-deep transmit queue. The low half of the entry is the data to shift. The high half is a control word that sets the frame length and the chip-select choice for that entry alone.

The block keeps a copy of the last control word. Narrow writes, and full-word writes whose top half is zero, reuse that copy. A full-word write with a non-zero top half replaces the copy, and the replaced value applies to the entry pushed in that same write. The shift engine drains the queue through a valid/ready interface, with the length and select fields already decoded. Frames coming back from the shifter fill an 8-deep receive queue. Software reads that queue through a popping address or through a peeking address.

A status word shows two level flags: transmit has room, and receive holds data. It also shows two sticky error flags, one for a write dropped while the queue was full and one for a read of an empty receive queue. Each sticky flag is cleared by writing a 1 to it.

Top module: `spi_txq_port`

## Requirements
- R1: After reset both queues are empty, `txq_valid` is 0, the held control word is 0x0000, and the status word (address 1) reads 0x1.
- R2: A write to address 0 with non-zero strobes that is neither all four strobes nor strobes [1:0] both set is a byte write. It pushes {held control, 8'h00, wdata[7:0]}.
- R3: A write to address 0 with strobes [1:0] set that is not a full-word write pushes {held control, wdata[15:0]}.
- R4: A write to address 0 with strobes 4'b1111 and wdata[31:16] equal to zero pushes {held control, wdata[15:0]} and leaves the held control word unchanged.
- R5: A write to address 0 with strobes 4'b1111 and wdata[31:16] non-zero loads wdata[31:16] into the held control word. It pushes {wdata[31:16], wdata[15:0]} in the same cycle, and later narrow writes use the new word.
- R6: `txq_len_m1` equals bits [19:16] of the head entry (frame length minus one). `txq_sel` equals bits [21:20] of the head entry.
- R7: The transmit queue holds 8 entries and presents them in write order on `txq_data`. An entry leaves on a cycle where `txq_valid` and `txq_ready` are both high.
- R8: A write to address 0 while the transmit queue holds 8 entries is dropped. It does not change the held control word, and it sets status bit 2. Bit 2 stays set until a write to address 1 with wdata[2]=1.
- R9: Status bit 0 is 1 while the transmit queue has fewer than 8 entries. Status bit 1 is 1 while the receive queue is not empty.
- R10: Frames offered on `rxq_valid`/`rxq_data` are accepted while `rxq_ready` is high, which holds while fewer than 8 are stored. A read at address 2 returns the oldest frame in bits [15:0] and removes it.
- R11: A read at address 3 returns the oldest receive frame without removing it.
- R12: A read at address 2 with the receive queue empty returns 0 and sets status bit 3. Bit 3 stays set until a write to address 1 with wdata[3]=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pop side effects) |
| bus_addr | input | 2 | Word address: 0 write port, 1 status, 2 receive pop, 3 receive peek |
| bus_wdata | input | 32 | Write data |
| bus_wstrb | input | 4 | Byte strobes of the write |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| txq_valid | output | 1 | Transmit head entry present |
| txq_ready | input | 1 | Shift engine takes the head entry |
| txq_data | output | 32 | Head entry {control, data} |
| txq_len_m1 | output | 4 | Decoded frame length minus one of the head entry |
| txq_sel | output | 2 | Decoded chip-select choice of the head entry |
| rxq_valid | input | 1 | Shift engine offers a received frame |
| rxq_ready | output | 1 | Receive queue can accept a frame |
| rxq_data | input | 16 | Received frame |

## Verification
A write or receive push captured at a clock edge shows on `txq_data`, on `rxq_ready` and in the status word just after that edge. The bench therefore drives at the falling edge and samples at the next falling edge. Read data is combinational from the address, so the bench samples it shortly after setting the address, before the edge that pops the frame. The sticky flags set on the edge that sees the offending access, and the bench reads them in the following cycle.

// File: rtl/spi_txq_pkg.sv
package spi_txq_pkg;

  localparam int HALF_W = 16;
  localparam int WORD_W = 32;

  localparam logic [1:0] A_TXWR = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_RXPOP = 2'd2;
  localparam logic [1:0] A_RXPEEK = 2'd3;

  localparam int ST_TXNF = 0;
  localparam int ST_RXNE = 1;
  localparam int ST_OVF = 2;
  localparam int ST_URF = 3;

  typedef enum logic [1:0] {
    WK_NONE = 2'd0,
    WK_BYTE = 2'd1,
    WK_HALF = 2'd2,
    WK_WORD = 2'd3
  } wr_kind_e;

  function automatic wr_kind_e classify(input logic [3:0] strb);
    if (strb == 4'b1111) return WK_WORD;
    else if (strb[1:0] == 2'b11) return WK_HALF;
    else if (strb != 4'b0000) return WK_BYTE;
    else return WK_NONE;
  endfunction

  function automatic logic [HALF_W-1:0] pick_data(input wr_kind_e k,
                                                  input logic [WORD_W-1:0] wd);
    if (k == WK_BYTE) return {8'h00, wd[7:0]};
    else return wd[HALF_W-1:0];
  endfunction

  function automatic logic [HALF_W-1:0] next_ctrl(input wr_kind_e k,
                                                  input logic [WORD_W-1:0] wd,
                                                  input logic [HALF_W-1:0] held);
    if (k == WK_WORD && wd[WORD_W-1:HALF_W] != '0) return wd[WORD_W-1:HALF_W];
    else return held;
  endfunction

  function automatic logic [3:0] ctrl_len_m1(input logic [HALF_W-1:0] c);
    return c[3:0];
  endfunction

  function automatic logic [1:0] ctrl_sel(input logic [HALF_W-1:0] c);
    return c[5:4];
  endfunction

endpackage

// File: rtl/spi_txq_fifo.sv
module spi_txq_fifo #(
  parameter int W = 32,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
  localparam logic [CW-1:0] FULLCNT = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wptr, rptr;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  assign full    = (cnt == FULLCNT);
  assign empty   = (cnt == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (do_push) wptr <= bump(wptr);
      if (do_pop) rptr <= bump(rptr);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/spi_txq_ctrl.sv
module spi_txq_ctrl
  import spi_txq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_req,
  input  logic [3:0]        wstrb,
  input  logic [WORD_W-1:0] wdata,
  input  logic              tx_full,
  output logic              push,
  output logic [WORD_W-1:0] push_entry,
  output logic              ovf_evt,
  output logic [HALF_W-1:0] held_ctrl
);
  wr_kind_e          kind;
  logic [HALF_W-1:0] ctrl_now;
  logic              takes;

  assign kind       = classify(wstrb);
  assign takes      = wr_req && (kind != WK_NONE);
  assign push       = takes && !tx_full;
  assign ovf_evt    = takes && tx_full;
  assign ctrl_now   = next_ctrl(kind, wdata, held_ctrl);
  assign push_entry = {ctrl_now, pick_data(kind, wdata)};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held_ctrl <= '0;
    else if (push) held_ctrl <= ctrl_now;
  end
endmodule

// File: rtl/spi_txq_regs.sv
module spi_txq_regs
  import spi_txq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_rd,
  input  logic [1:0]        bus_addr,
  input  logic [1:0]        sts_clr,
  input  logic              ovf_evt,
  input  logic              tx_full,
  input  logic              rx_empty,
  input  logic [HALF_W-1:0] rx_head,
  output logic              rx_pop,
  output logic              urf_evt,
  output logic              sts_ovf,
  output logic              sts_urf,
  output logic [WORD_W-1:0] bus_rdata
);
  logic              pop_req;
  logic [HALF_W-1:0] head_vis;
  logic [3:0]        sts;

  assign pop_req  = bus_rd && (bus_addr == A_RXPOP);
  assign rx_pop   = pop_req && !rx_empty;
  assign urf_evt  = pop_req && rx_empty;
  assign head_vis = rx_empty ? '0 : rx_head;

  always_comb begin
    sts = '0;
    sts[ST_TXNF] = !tx_full;
    sts[ST_RXNE] = !rx_empty;
    sts[ST_OVF]  = sts_ovf;
    sts[ST_URF]  = sts_urf;
  end

  always_comb begin
    case (bus_addr)
      A_STAT:   bus_rdata = {28'h0, sts};
      A_RXPOP:  bus_rdata = {16'h0, head_vis};
      A_RXPEEK: bus_rdata = {16'h0, head_vis};
      default:  bus_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_ovf <= 1'b0;
      sts_urf <= 1'b0;
    end else begin
      if (ovf_evt) sts_ovf <= 1'b1;
      else if (sts_clr[0]) sts_ovf <= 1'b0;
      if (urf_evt) sts_urf <= 1'b1;
      else if (sts_clr[1]) sts_urf <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_txq_port.sv
module spi_txq_port
  import spi_txq_pkg::*;
#(
  parameter int TX_DEPTH = 8,
  parameter int RX_DEPTH = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [1:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  input  logic [3:0]  bus_wstrb,
  output logic [31:0] bus_rdata,
  output logic        txq_valid,
  input  logic        txq_ready,
  output logic [31:0] txq_data,
  output logic [3:0]  txq_len_m1,
  output logic [1:0]  txq_sel,
  input  logic        rxq_valid,
  output logic        rxq_ready,
  input  logic [15:0] rxq_data
);
  logic              tx_wr_req, tx_push, tx_full, tx_empty, ovf_evt;
  logic [WORD_W-1:0] push_entry, tx_head;
  logic [HALF_W-1:0] held_ctrl, rx_head;
  logic              rx_full, rx_empty, rx_pop, urf_evt, sts_ovf, sts_urf;
  logic [1:0]        sts_clr;

  assign tx_wr_req = bus_wr && (bus_addr == A_TXWR);
  assign sts_clr   = (bus_wr && bus_addr == A_STAT) ?
                     bus_wdata[ST_URF:ST_OVF] : 2'b00;

  spi_txq_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_req(tx_wr_req), .wstrb(bus_wstrb),
    .wdata(bus_wdata), .tx_full(tx_full), .push(tx_push),
    .push_entry(push_entry), .ovf_evt(ovf_evt), .held_ctrl(held_ctrl)
  );

  spi_txq_fifo #(.W(WORD_W), .DEPTH(TX_DEPTH)) u_txf (
    .clk(clk), .rst_n(rst_n), .push(tx_push), .din(push_entry),
    .pop(txq_ready), .dout(tx_head), .full(tx_full), .empty(tx_empty)
  );

  spi_txq_fifo #(.W(HALF_W), .DEPTH(RX_DEPTH)) u_rxf (
    .clk(clk), .rst_n(rst_n), .push(rxq_valid), .din(rxq_data),
    .pop(rx_pop), .dout(rx_head), .full(rx_full), .empty(rx_empty)
  );

  spi_txq_regs u_regs (
    .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .sts_clr(sts_clr), .ovf_evt(ovf_evt), .tx_full(tx_full),
    .rx_empty(rx_empty), .rx_head(rx_head), .rx_pop(rx_pop),
    .urf_evt(urf_evt), .sts_ovf(sts_ovf), .sts_urf(sts_urf),
    .bus_rdata(bus_rdata)
  );

  assign txq_valid  = !tx_empty;
  assign txq_data   = tx_head;
  assign txq_len_m1 = ctrl_len_m1(tx_head[WORD_W-1:HALF_W]);
  assign txq_sel    = ctrl_sel(tx_head[WORD_W-1:HALF_W]);
  assign rxq_ready  = !rx_full;
endmodule

// File: rtl/spi_txq_port_chk.sv
module spi_txq_port_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_rd,
  input logic [1:0]  bus_addr,
  input logic [31:0] bus_wdata,
  input logic [3:0]  bus_wstrb,
  input logic [31:0] bus_rdata,
  input logic        tx_wr_req,
  input logic        tx_push,
  input logic        tx_full,
  input logic [31:0] push_entry,
  input logic [15:0] held_ctrl,
  input logic        sts_ovf,
  input logic [1:0]  sts_clr,
  input logic        rx_empty,
  input logic        rxq_valid
);
  AST_FULL_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    tx_wr_req && tx_full |-> !tx_push); // R8

  AST_FULL_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    tx_wr_req && tx_full && bus_wstrb != 4'b0000 |=> sts_ovf); // R8

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    sts_ovf && !sts_clr[0] |=> sts_ovf); // R8

  AST_ZERO_TOP_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    tx_wr_req && bus_wstrb == 4'b1111 && bus_wdata[31:16] == 16'h0
    |=> $stable(held_ctrl)); // R4

  AST_NEW_CTRL_NOW: assert property (@(posedge clk) disable iff (!rst_n)
    tx_push && bus_wstrb == 4'b1111 && bus_wdata[31:16] != 16'h0
    |-> push_entry[31:16] == bus_wdata[31:16]); // R5

  AST_BYTE_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    tx_push && !bus_wstrb[1] |-> push_entry[15:8] == 8'h00); // R2

  AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && bus_addr == 2'd2 && rx_empty |-> bus_rdata == 32'h0); // R12

  AST_PEEK_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && bus_addr == 2'd3 && !rx_empty |=> !rx_empty); // R11

  AST_RX_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    rxq_valid && !(bus_rd && bus_addr == 2'd2) |=> !rx_empty); // R10
endmodule

bind spi_txq_port spi_txq_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_wstrb(bus_wstrb), .bus_rdata(bus_rdata),
  .tx_wr_req(tx_wr_req), .tx_push(tx_push), .tx_full(tx_full),
  .push_entry(push_entry), .held_ctrl(held_ctrl), .sts_ovf(sts_ovf),
  .sts_clr(sts_clr), .rx_empty(rx_empty), .rxq_valid(rxq_valid)
);

// File: tb/spi_txq_port_test.sv
module spi_txq_port_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 8;
  // {strobes, write data, expected entry}
  localparam logic [67:0] VEC [NV] = '{
    {4'b1111, 32'h0003_00AA, 32'h0003_00AA},
    {4'b0001, 32'hFFFF_12BB, 32'h0003_00BB},
    {4'b0011, 32'h5555_1234, 32'h0003_1234},
    {4'b1111, 32'h0000_BEEF, 32'h0003_BEEF},
    {4'b1111, 32'h0A21_0001, 32'h0A21_0001},
    {4'b0001, 32'h0000_00FE, 32'h0A21_00FE},
    {4'b0010, 32'h1111_2277, 32'h0A21_0077},
    {4'b1111, 32'h8000_0000, 32'h8000_0000}
  };

  logic        clk = 0, rst_n = 0;
  logic        bus_wr = 0, bus_rd = 0, txq_ready = 0, rxq_valid = 0;
  logic [1:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic [3:0]  bus_wstrb = 0;
  logic [15:0] rxq_data = 0;
  logic [31:0] bus_rdata, txq_data;
  logic [3:0]  txq_len_m1;
  logic [1:0]  txq_sel;
  logic        txq_valid, rxq_ready;
  int checks = 0, errors = 0;
  bit done = 0;

  spi_txq_port uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wstrb(bus_wstrb),
    .bus_rdata(bus_rdata), .txq_valid(txq_valid), .txq_ready(txq_ready),
    .txq_data(txq_data), .txq_len_m1(txq_len_m1), .txq_sel(txq_sel),
    .rxq_valid(rxq_valid), .rxq_ready(rxq_ready), .rxq_data(rxq_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d, input logic [3:0] s);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d; bus_wstrb = s;
    @(negedge clk);
    bus_wr = 0; bus_wstrb = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 0;
  endtask

  task automatic pop_tx(input string req, input logic [31:0] exp);
    @(negedge clk);
    check(req, {31'h0, txq_valid}, 32'h1);
    check(req, txq_data, exp);
    txq_ready = 1;
    @(negedge clk);
    txq_ready = 0;
  endtask

  task automatic push_rx(input logic [15:0] d);
    @(negedge clk);
    rxq_valid = 1; rxq_data = d;
    @(negedge clk);
    rxq_valid = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 txq_valid", {31'h0, txq_valid}, 32'h0);
    rd(2'd1, r); check("R1 status", r, 32'h1);
    wr(2'd0, 32'h0000_00C3, 4'b0001);
    pop_tx("R1 held ctrl zero", 32'h0000_00C3);

    // table walk: R2 R3 R4 R5 R6
    for (int i = 0; i < NV; i++) begin
      wr(2'd0, VEC[i][63:32], VEC[i][67:64]);
      @(negedge clk);
      check("R6 len", {28'h0, txq_len_m1}, {28'h0, VEC[i][19:16]});
      check("R6 sel", {30'h0, txq_sel}, {30'h0, VEC[i][21:20]});
      pop_tx("R2/R3/R4/R5 entry", VEC[i][31:0]);
    end
    check("R7 empty after walk", {31'h0, txq_valid}, 32'h0);

    // R7 depth and order, R8 overflow
    for (int i = 0; i < 8; i++) wr(2'd0, 32'h0000_0040 + i, 4'b0001);
    rd(2'd1, r); check("R9 tx full status", r, 32'h0);
    wr(2'd0, 32'h0055_0099, 4'b1111);
    rd(2'd1, r); check("R8 overflow flag", r, 32'h4);
    for (int i = 0; i < 8; i++) pop_tx("R7 order", 32'h8000_0040 + i);
    @(negedge clk);
    check("R8 dropped entry absent", {31'h0, txq_valid}, 32'h0);
    wr(2'd0, 32'h0000_0077, 4'b0001);
    pop_tx("R8 held ctrl unchanged", 32'h8000_0077);
    rd(2'd1, r); check("R8 flag sticky", r, 32'h5);
    wr(2'd1, 32'h0000_0004, 4'b1111);
    rd(2'd1, r); check("R8 flag cleared", r, 32'h1);

    // receive side: R9 R10 R11 R12
    push_rx(16'h1111); push_rx(16'h2222); push_rx(16'h3333);
    rd(2'd1, r); check("R9 rx not empty", r, 32'h3);
    rd(2'd3, r); check("R11 peek", r, 32'h1111);
    rd(2'd3, r); check("R11 peek again", r, 32'h1111);
    rd(2'd2, r); check("R10 pop 1", r, 32'h1111);
    rd(2'd2, r); check("R10 pop 2", r, 32'h2222);
    rd(2'd2, r); check("R10 pop 3", r, 32'h3333);
    rd(2'd1, r); check("R12 no flag yet", r, 32'h1);
    rd(2'd2, r); check("R12 empty read zero", r, 32'h0);
    rd(2'd1, r); check("R12 underflow flag", r, 32'h9);
    wr(2'd1, 32'h0000_0008, 4'b1111);
    rd(2'd1, r); check("R12 flag cleared", r, 32'h1);

    for (int i = 0; i < 8; i++) push_rx(16'hA000 + 16'(i));
    check("R10 rx ready low when full", {31'h0, rxq_ready}, 32'h0);
    push_rx(16'hDEAD);
    for (int i = 0; i < 8; i++) begin
      rd(2'd2, r); check("R10 rx order", r, 32'h0000_A000 + i);
    end
    check("R10 rx ready again", {31'h0, rxq_ready}, 32'h1);
    rd(2'd1, r); check("R10 extra frame not stored", r, 32'h1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule